// File: doc/BRIEF.md
# Delayed Read Completion Matcher

This block decides whether an inbound memory read from an external bus master can be answered from data that an earlier delayed read has already fetched. It keeps a small table of delayed read entries. Each entry holds an address, the read command it was issued with, a valid flag and a data-ready flag. When a master presents a read, the block compares it against every valid entry at the same time. A hit whose data has arrived returns the data and retires the entry. Any other outcome answers Retry. A read that hits nothing claims a free entry and launches a new internal read request.

A configuration input controls how commands are compared. When it is clear, a hit needs the same address and the same read command. When it is set, the three memory read commands count as one, so a hit depends on the address alone. This serves older masters that retry a read with a different read command. The internal read logic reports completion through a fill strobe that carries the entry index. Data storage and bus signalling sit outside this block.

Top module: `drc_matcher`

## Requirements
- R1: After reset every entry is invalid, and `resp_data`, `resp_retry` and `issue_valid` are low.
- R2: Only three command codes take part in matching: 4'h6 (memory read), 4'hE (memory read line) and 4'hC (memory read multiple). A request carrying any other code gets Retry. It never hits and never allocates.
- R3: With `alias_en` low, an entry hits only if both its address and its command equal the request's.
- R4: With `alias_en` high, any of the three read codes hits an entry holding any of the three read codes at the same address.
- R5: A hit on an entry whose data is ready raises `resp_data` with `resp_idx` set to that entry, raises no retry, and frees the entry.
- R6: A hit on an entry whose data is not ready answers Retry and allocates nothing.
- R7: A read that hits no entry while an entry is free claims the lowest-index free entry. The response is Retry together with `issue_valid`, and `issue_addr`, `issue_cmd` and `issue_idx` carry the request's address, its command and the claimed entry.
- R8: A read that hits no entry while all entries are valid answers Retry, and `issue_valid` stays low.
- R9: When more than one entry hits, the entry with the lowest index is used.
- R10: `fill_valid` marks entry `fill_idx` as data-ready if that entry is valid. A fill aimed at an invalid entry has no effect, and a newly claimed entry always starts not ready.
- R11: Each request is answered in the cycle after it is presented, with exactly one of `resp_data` and `resp_retry`. In a cycle that follows no request, both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alias_en | input | 1 | Treat the three read commands as equal when comparing |
| req_valid | input | 1 | An inbound read is presented this cycle |
| req_addr | input | ADDR_W | Address of the inbound read |
| req_cmd | input | 4 | Bus command of the inbound read |
| fill_valid | input | 1 | Internal read data has arrived for one entry |
| fill_idx | input | IDX_W | Entry whose data has arrived |
| resp_data | output | 1 | Return stored data; the delayed read is complete |
| resp_retry | output | 1 | Tell the master to retry |
| resp_idx | output | IDX_W | Entry whose data is returned |
| issue_valid | output | 1 | Start a new internal read |
| issue_addr | output | ADDR_W | Address of the new internal read |
| issue_cmd | output | 4 | Command of the new internal read |
| issue_idx | output | IDX_W | Entry claimed for the new internal read |

## Verification
The bench stores a memory read multiple and then retries it as a plain memory read with aliasing off and with aliasing on.
- A comparator that ignores the command would return data too early.
- A comparator that never aliases would allocate a duplicate entry.

The bench builds a case where two entries both hit, which exposes a priority encoder that favours the highest index.

The bench retries a pending entry and fills the table to capacity.
- A design that allocates on a pending hit would issue the same read twice.
- A design that allocates when the table is full would overwrite an entry.

The bench also sends a fill to an empty entry before that entry is claimed. A design that accepts the stray fill would return data the internal read never delivered.

// File: rtl/drc_pkg.sv
package drc_pkg;

  localparam int CMD_W = 4;

  localparam logic [CMD_W-1:0] CMD_MEM_RD      = 4'h6;
  localparam logic [CMD_W-1:0] CMD_MEM_RD_LINE = 4'hE;
  localparam logic [CMD_W-1:0] CMD_MEM_RD_MULT = 4'hC;

  // True for the three memory read codes that may be served from a stored entry.
  function automatic logic is_mem_read(input logic [CMD_W-1:0] c);
    return (c == CMD_MEM_RD) || (c == CMD_MEM_RD_LINE) || (c == CMD_MEM_RD_MULT);
  endfunction

  // Command comparison rule. Aliasing folds all read codes into one class.
  function automatic logic cmd_match(input logic [CMD_W-1:0] stored,
                                     input logic [CMD_W-1:0] incoming,
                                     input logic             alias_on);
    if (!is_mem_read(stored) || !is_mem_read(incoming)) return 1'b0;
    return alias_on ? 1'b1 : (stored == incoming);
  endfunction

endpackage

// File: rtl/drc_first_set.sv
// Lowest-index set bit finder, used for both hit selection and free-entry pick.
module drc_first_set #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/drc_entry.sv
// One delayed read table slot with its own comparator.
module drc_entry
  import drc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              claim,
  input  logic              retire,
  input  logic              fill,
  input  logic [ADDR_W-1:0] claim_addr,
  input  logic [CMD_W-1:0]  claim_cmd,
  input  logic              alias_on,
  input  logic [ADDR_W-1:0] cmp_addr,
  input  logic [CMD_W-1:0]  cmp_cmd,
  output logic              valid,
  output logic              ready,
  output logic              hit
);
  logic [ADDR_W-1:0] addr_q;
  logic [CMD_W-1:0]  cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      ready  <= 1'b0;
      addr_q <= '0;
      cmd_q  <= '0;
    end else if (claim) begin
      valid  <= 1'b1;
      ready  <= 1'b0;
      addr_q <= claim_addr;
      cmd_q  <= claim_cmd;
    end else if (retire) begin
      valid  <= 1'b0;
      ready  <= 1'b0;
    end else if (fill && valid) begin
      ready  <= 1'b1;
    end
  end

  assign hit = valid && (addr_q == cmp_addr) && cmd_match(cmd_q, cmp_cmd, alias_on);
endmodule

// File: rtl/drc_matcher.sv
module drc_matcher
  import drc_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alias_en,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_cmd,
  input  logic              fill_valid,
  input  logic [IDX_W-1:0]  fill_idx,
  output logic              resp_data,
  output logic              resp_retry,
  output logic [IDX_W-1:0]  resp_idx,
  output logic              issue_valid,
  output logic [ADDR_W-1:0] issue_addr,
  output logic [3:0]        issue_cmd,
  output logic [IDX_W-1:0]  issue_idx
);
  logic [ENTRIES-1:0] entry_valid, entry_ready, entry_hit;
  logic [ENTRIES-1:0] claim_vec, retire_vec;
  logic               hit_found, free_found;
  logic [IDX_W-1:0]   hit_idx, free_idx;

  // Named decision events, also observed by the checker.
  logic req_is_read, ev_hit_ready, ev_hit_wait, ev_alloc, ev_full, ev_reject;

  drc_first_set #(.N(ENTRIES), .IW(IDX_W)) u_hit_pick (
    .vec(entry_hit), .found(hit_found), .idx(hit_idx)
  );

  drc_first_set #(.N(ENTRIES), .IW(IDX_W)) u_free_pick (
    .vec(~entry_valid), .found(free_found), .idx(free_idx)
  );

  assign req_is_read  = is_mem_read(req_cmd);
  assign ev_hit_ready = req_valid && hit_found && entry_ready[hit_idx];
  assign ev_hit_wait  = req_valid && hit_found && !entry_ready[hit_idx];
  assign ev_alloc     = req_valid && req_is_read && !hit_found && free_found;
  assign ev_full      = req_valid && req_is_read && !hit_found && !free_found;
  assign ev_reject    = req_valid && !req_is_read;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    assign claim_vec[g]  = ev_alloc && (free_idx == IDX_W'(g));
    assign retire_vec[g] = ev_hit_ready && (hit_idx == IDX_W'(g));

    drc_entry #(.ADDR_W(ADDR_W)) u_entry (
      .clk       (clk),
      .rst_n     (rst_n),
      .claim     (claim_vec[g]),
      .retire    (retire_vec[g]),
      .fill      (fill_valid && (fill_idx == IDX_W'(g))),
      .claim_addr(req_addr),
      .claim_cmd (req_cmd),
      .alias_on  (alias_en),
      .cmp_addr  (req_addr),
      .cmp_cmd   (req_cmd),
      .valid     (entry_valid[g]),
      .ready     (entry_ready[g]),
      .hit       (entry_hit[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_data   <= 1'b0;
      resp_retry  <= 1'b0;
      resp_idx    <= '0;
      issue_valid <= 1'b0;
      issue_addr  <= '0;
      issue_cmd   <= '0;
      issue_idx   <= '0;
    end else begin
      resp_data   <= ev_hit_ready;
      resp_retry  <= ev_hit_wait || ev_alloc || ev_full || ev_reject;
      issue_valid <= ev_alloc;
      if (ev_hit_ready) resp_idx <= hit_idx;
      if (ev_alloc) begin
        issue_addr <= req_addr;
        issue_cmd  <= req_cmd;
        issue_idx  <= free_idx;
      end
    end
  end
endmodule

// File: rtl/drc_matcher_chk.sv
module drc_matcher_chk
  import drc_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [3:0]         req_cmd,
  input logic               resp_data,
  input logic               resp_retry,
  input logic [IDX_W-1:0]   resp_idx,
  input logic               issue_valid,
  input logic [IDX_W-1:0]   issue_idx,
  input logic [ENTRIES-1:0] entry_valid,
  input logic               ev_hit_wait,
  input logic               ev_full
);
  a_r11_single_answer: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_data && resp_retry));

  a_r11_req_answered: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (resp_data || resp_retry));

  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(resp_data || resp_retry));

  a_r2_nonread_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !is_mem_read(req_cmd)) |=> (resp_retry && !issue_valid));

  a_r5_served_entry_freed: assert property (@(posedge clk) disable iff (!rst_n)
    resp_data |-> !entry_valid[resp_idx]);

  a_r6_pending_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit_wait |=> (resp_retry && !issue_valid));

  a_r7_issue_slot_valid: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (entry_valid[issue_idx] && resp_retry));

  a_r8_full_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    ev_full |=> (resp_retry && !issue_valid && $stable(entry_valid)));
endmodule

bind drc_matcher drc_matcher_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_cmd    (req_cmd),
  .resp_data  (resp_data),
  .resp_retry (resp_retry),
  .resp_idx   (resp_idx),
  .issue_valid(issue_valid),
  .issue_idx  (issue_idx),
  .entry_valid(entry_valid),
  .ev_hit_wait(ev_hit_wait),
  .ev_full    (ev_full)
);

// File: tb/drc_matcher_tb.sv
module drc_matcher_tb_top;
  localparam int ENTRIES = 4;
  localparam int ADDR_W  = 32;
  localparam int IDX_W   = 2;
  localparam logic [3:0] MR = 4'h6, MRL = 4'hE, MRM = 4'hC;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              alias_en = 1'b0;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [3:0]        req_cmd = '0;
  logic              fill_valid = 1'b0;
  logic [IDX_W-1:0]  fill_idx = '0;
  logic              resp_data, resp_retry, issue_valid;
  logic [IDX_W-1:0]  resp_idx, issue_idx;
  logic [ADDR_W-1:0] issue_addr;
  logic [3:0]        issue_cmd;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  drc_matcher #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .alias_en(alias_en),
    .req_valid(req_valid), .req_addr(req_addr), .req_cmd(req_cmd),
    .fill_valid(fill_valid), .fill_idx(fill_idx),
    .resp_data(resp_data), .resp_retry(resp_retry), .resp_idx(resp_idx),
    .issue_valid(issue_valid), .issue_addr(issue_addr),
    .issue_cmd(issue_cmd), .issue_idx(issue_idx)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Present one request; on return the registered answer is visible.
  task automatic send(input logic [31:0] a, input logic [3:0] c, input logic al);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_cmd = c; alias_en = al;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic fill(input int i);
    @(negedge clk);
    fill_valid = 1'b1; fill_idx = IDX_W'(i);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  // Expected answer: served from entry sidx, or retry, optionally with a new issue.
  task automatic expect_ans(input string req, input bit served, input int sidx,
                            input bit issued, input int iidx,
                            input logic [31:0] a, input logic [3:0] c);
    check({req, " resp_data"}, 64'(resp_data), 64'(served));
    check({req, " resp_retry"}, 64'(resp_retry), 64'(!served));
    if (served) check({req, " resp_idx"}, 64'(resp_idx), 64'(sidx));
    check({req, " issue_valid"}, 64'(issue_valid), 64'(issued));
    if (issued) begin
      check({req, " issue_idx"}, 64'(issue_idx), 64'(iidx));
      check({req, " issue_addr"}, 64'(issue_addr), 64'(a));
      check({req, " issue_cmd"}, 64'(issue_cmd), 64'(c));
    end
  endtask

  task automatic t_reset;
    check("R1 resp_data", 64'(resp_data), 64'd0);
    check("R1 resp_retry", 64'(resp_retry), 64'd0);
    check("R1 issue_valid", 64'(issue_valid), 64'd0);
  endtask

  task automatic t_alloc_pending_serve;
    send(32'h100, MR, 1'b0);
    expect_ans("R7 first miss", 0, 0, 1, 0, 32'h100, MR);
    send(32'h100, MR, 1'b0);
    expect_ans("R6 pending hit", 0, 0, 0, 0, 0, 0);
    fill(0);
    check("R11 idle resp_data", 64'(resp_data), 64'd0);
    check("R11 idle resp_retry", 64'(resp_retry), 64'd0);
    send(32'h100, MR, 1'b0);
    expect_ans("R5 ready hit", 1, 0, 0, 0, 0, 0);
    send(32'h100, MR, 1'b0);
    expect_ans("R5 entry freed, R7 realloc", 0, 0, 1, 0, 32'h100, MR);
    fill(0);
    send(32'h100, MR, 1'b0);
    expect_ans("R5 drain", 1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_alias;
    send(32'h200, MRM, 1'b0);
    expect_ans("R7 mrm miss", 0, 0, 1, 0, 32'h200, MRM);
    fill(0);
    send(32'h200, MR, 1'b0);
    expect_ans("R3 cmd differs no alias", 0, 0, 1, 1, 32'h200, MR);
    fill(1);
    send(32'h200, MRL, 1'b1);
    expect_ans("R4 R9 alias hit lowest", 1, 0, 0, 0, 0, 0);
    send(32'h200, MR, 1'b0);
    expect_ans("R3 exact cmd hit", 1, 1, 0, 0, 0, 0);
    send(32'h204, MR, 1'b1);
    expect_ans("R4 alias needs address", 0, 0, 1, 0, 32'h204, MR);
    fill(0);
    send(32'h204, MRL, 1'b1);
    expect_ans("R4 alias drain", 1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_nonread;
    send(32'h300, 4'h7, 1'b1);
    expect_ans("R2 write code", 0, 0, 0, 0, 0, 0);
    send(32'h300, 4'h2, 1'b0);
    expect_ans("R2 io read code", 0, 0, 0, 0, 0, 0);
    send(32'h300, MR, 1'b0);
    expect_ans("R2 nothing allocated", 0, 0, 1, 0, 32'h300, MR);
    fill(0);
    send(32'h300, MR, 1'b0);
    expect_ans("R2 drain", 1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_full;
    fill(3);
    for (int i = 0; i < ENTRIES; i++) begin
      send(32'h10 * (i + 1), MRL, 1'b0);
      expect_ans("R7 fill table", 0, 0, 1, i, 32'h10 * (i + 1), MRL);
    end
    send(32'h50, MR, 1'b0);
    expect_ans("R8 table full", 0, 0, 0, 0, 0, 0);
    send(32'h40, MRL, 1'b0);
    expect_ans("R10 stray fill ignored", 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < ENTRIES; i++) fill(i);
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      send(32'h10 * (i + 1), MRL, 1'b0);
      expect_ans("R10 R5 drain after fill", 1, i, 0, 0, 0, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_alloc_pending_serve;
    t_alias;
    t_nonread;
    t_full;
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule